// File: doc/BRIEF.md
# Power-of-Two Gain PID Compensator

This block closes a voltage-mode converter loop in hardware. Once per switching period a start strobe arrives with a fresh ADC sample of the output voltage. The block subtracts the sample from a setpoint and forms proportional, integral and derivative contributions. Every gain is a power of two, so each one is a barrel shift and no multiplier is used. Each contribution is limited on its own to a symmetric bound. Their sum is then limited to a duty window and presented as the duty word for the next PWM period, with a one-cycle done pulse.

The integral path has two gain stages. One shift scales the error before it enters the accumulator, and a second shift scales the accumulator into the integral contribution. The accumulator itself is bounded, which keeps it from winding up. The work runs as a fixed five-step sequence: error, proportional, accumulator, derivative, sum. The result is ready after a handful of clock cycles, far inside a switching period of about 160 counts.

Top module: `shift_pid_ctrl`

## Requirements
- R1: On the clock edge that samples start high while the block is idle, the error is captured as setpoint minus sample, both taken as unsigned and the difference as a signed value one bit wider.
- R2: The proportional contribution is the error shifted left by kp_shift, limited to the range from -p_lim to +p_lim.
- R3: Each computation adds the error shifted left by ki_pre_shift to the accumulator, and the result is limited to the range from -i_lim to +i_lim.
- R4: The integral contribution is the updated accumulator arithmetically shifted right by ki_post_shift, rounding toward minus infinity (for example, -270 shifted by 3 gives -34).
- R5: The derivative contribution is the current error minus the error of the previous computation, shifted left by kd_shift and limited to the range from -d_lim to +d_lim. The stored previous error is replaced only after this contribution has been formed.
- R6: The duty word is the signed sum of the three contributions limited to the window from duty_min to duty_max. A sum below duty_min gives duty_min and a sum above duty_max gives duty_max. If duty_min exceeds duty_max, duty_min wins for any sum below it.
- R7: If start is sampled at clock edge N, done is high for exactly one cycle, from edge N+5 to edge N+6. A start that arrives while a computation is in progress is ignored.
- R8: After reset, done is low, the accumulator and previous error are zero, and the duty output follows duty_min until the first computation completes.
- R9: The duty output changes only on the edge that raises done. Between computations it holds its value regardless of sample, setpoint or duty_min.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins one computation when the block is idle |
| sample | input | SAMPLE_W | ADC reading of the output voltage, unsigned |
| setpoint | input | SAMPLE_W | Target reading, unsigned |
| kp_shift | input | SHIFT_W | Left shift for the proportional gain |
| ki_pre_shift | input | SHIFT_W | Left shift applied to the error before accumulation |
| ki_post_shift | input | SHIFT_W | Arithmetic right shift applied to the accumulator |
| kd_shift | input | SHIFT_W | Left shift for the derivative gain |
| p_lim | input | LIM_W | Magnitude bound of the proportional contribution |
| i_lim | input | LIM_W | Magnitude bound of the accumulator |
| d_lim | input | LIM_W | Magnitude bound of the derivative contribution |
| duty_min | input | DUTY_W | Lower duty limit |
| duty_max | input | DUTY_W | Upper duty limit |
| duty | output | DUTY_W | Duty word |
| done | output | 1 | One-cycle pulse when a new duty word is valid |

## Verification
The assertions check several properties on every cycle. Each bounded contribution and the accumulator stay inside the limits in force when they were written. The duty word lands inside its window whenever that window is well formed. The done pulse lasts one cycle and follows an accepted start by exactly five edges. The sequence only leaves idle through an accepted start, and the previous error tracks the captured error. Other behaviours need the directed scenarios. These are the exact arithmetic values, the floor rounding of negative accumulators, saturation of the accumulator over repeated periods, the derivative reference after reset, precedence when the duty limits cross, and duty holding steady while the inputs move between computations.

// File: rtl/shpid_pkg.sv
package shpid_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PROP,
        PH_INTEG,
        PH_DERIV,
        PH_SUM
    } phase_e;

endpackage

// File: rtl/shpid_sym_clamp.sv
module shpid_sym_clamp #(
    parameter int IN_W  = 36,
    parameter int LIM_W = 15
) (
    input  logic signed [IN_W-1:0]  val_i,
    input  logic        [LIM_W-1:0] lim_i,
    output logic signed [LIM_W:0]   val_o
);
    localparam int PAD_W = IN_W - LIM_W;

    logic signed [IN_W-1:0] hi_bound;
    logic signed [IN_W-1:0] lo_bound;

    assign hi_bound = $signed({{PAD_W{1'b0}}, lim_i});
    assign lo_bound = -hi_bound;

    always_comb begin
        if (val_i > hi_bound) begin
            val_o = hi_bound[LIM_W:0];
        end else if (val_i < lo_bound) begin
            val_o = lo_bound[LIM_W:0];
        end else begin
            val_o = val_i[LIM_W:0];
        end
    end

    always_comb begin
        AST_CLAMP_WIDTH: assert (IN_W >= LIM_W + 2) else $error("clamp input too narrow"); // R2
    end

endmodule

// File: rtl/shpid_range_clamp.sv
module shpid_range_clamp #(
    parameter int IN_W  = 36,
    parameter int OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  val_i,
    input  logic        [OUT_W-1:0] lo_i,
    input  logic        [OUT_W-1:0] hi_i,
    output logic        [OUT_W-1:0] val_o
);
    localparam int PAD_W = IN_W - OUT_W;

    logic signed [IN_W-1:0] lo_w;
    logic signed [IN_W-1:0] hi_w;

    assign lo_w = $signed({{PAD_W{1'b0}}, lo_i});
    assign hi_w = $signed({{PAD_W{1'b0}}, hi_i});

    always_comb begin
        if (val_i < lo_w) begin
            val_o = lo_i;
        end else if (val_i > hi_w) begin
            val_o = hi_i;
        end else begin
            val_o = val_i[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/shpid_phase_seq.sv
module shpid_phase_seq
    import shpid_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   done_o
);
    typedef struct packed {
        phase_e phase;
        logic   done;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.phase)
            PH_IDLE:  if (start_i) seq_d.phase = PH_PROP;
            PH_PROP:  seq_d.phase = PH_INTEG;
            PH_INTEG: seq_d.phase = PH_DERIV;
            PH_DERIV: seq_d.phase = PH_SUM;
            PH_SUM: begin
                seq_d.phase = PH_IDLE;
                seq_d.done  = 1'b1;
            end
            default:  seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign done_o  = seq_q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i && (phase_o == PH_IDLE), 5)) else $error("done latency wrong"); // R7
    AST_ENTRY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_PROP) |-> ($past(phase_o) == PH_IDLE)) else $error("start accepted while busy"); // R7

endmodule

// File: rtl/shift_pid_ctrl.sv
module shift_pid_ctrl
    import shpid_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int SHIFT_W  = 3,
    parameter int LIM_W    = 15,
    parameter int DUTY_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] setpoint,
    input  logic [SHIFT_W-1:0]  kp_shift,
    input  logic [SHIFT_W-1:0]  ki_pre_shift,
    input  logic [SHIFT_W-1:0]  ki_post_shift,
    input  logic [SHIFT_W-1:0]  kd_shift,
    input  logic [LIM_W-1:0]    p_lim,
    input  logic [LIM_W-1:0]    i_lim,
    input  logic [LIM_W-1:0]    d_lim,
    input  logic [DUTY_W-1:0]   duty_min,
    input  logic [DUTY_W-1:0]   duty_max,
    output logic [DUTY_W-1:0]   duty,
    output logic                done
);
    localparam int ERR_W     = SAMPLE_W + 1;
    localparam int TERM_W    = LIM_W + 1;
    localparam int SHIFT_MAX = (1 << SHIFT_W) - 1;
    localparam int WIDE_W    = ERR_W + SHIFT_MAX + LIM_W + DUTY_W + 3;

    typedef struct packed {
        logic signed [ERR_W-1:0]  err;
        logic signed [ERR_W-1:0]  eprev;
        logic signed [TERM_W-1:0] pterm;
        logic signed [TERM_W-1:0] acc;
        logic signed [TERM_W-1:0] iterm;
        logic signed [TERM_W-1:0] dterm;
        logic        [DUTY_W-1:0] duty;
        logic                     valid;
    } state_t;

    state_t st_d;
    state_t st_q;
    phase_e phase_q;

    logic signed [ERR_W-1:0]  err_new;
    logic signed [WIDE_W-1:0] err_w;
    logic signed [WIDE_W-1:0] eprev_w;
    logic signed [WIDE_W-1:0] acc_w;
    logic signed [WIDE_W-1:0] p_raw;
    logic signed [WIDE_W-1:0] acc_raw;
    logic signed [WIDE_W-1:0] d_raw;
    logic signed [WIDE_W-1:0] sum_raw;
    logic signed [TERM_W-1:0] p_sat;
    logic signed [TERM_W-1:0] acc_sat;
    logic signed [TERM_W-1:0] d_sat;
    logic signed [TERM_W-1:0] i_new;
    logic        [DUTY_W-1:0] duty_sat;

    shpid_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .phase_o (phase_q),
        .done_o  (done)
    );

    // widen everything so no shift or sum can wrap before saturation
    assign err_new = $signed({1'b0, setpoint}) - $signed({1'b0, sample});
    assign err_w   = {{(WIDE_W-ERR_W){st_q.err[ERR_W-1]}}, st_q.err};
    assign eprev_w = {{(WIDE_W-ERR_W){st_q.eprev[ERR_W-1]}}, st_q.eprev};
    assign acc_w   = {{(WIDE_W-TERM_W){st_q.acc[TERM_W-1]}}, st_q.acc};

    assign p_raw   = err_w <<< kp_shift;
    assign acc_raw = acc_w + (err_w <<< ki_pre_shift);
    assign d_raw   = (err_w - eprev_w) <<< kd_shift;
    assign sum_raw = {{(WIDE_W-TERM_W){st_q.pterm[TERM_W-1]}}, st_q.pterm}
                   + {{(WIDE_W-TERM_W){st_q.iterm[TERM_W-1]}}, st_q.iterm}
                   + {{(WIDE_W-TERM_W){st_q.dterm[TERM_W-1]}}, st_q.dterm};

    shpid_sym_clamp #(.IN_W(WIDE_W), .LIM_W(LIM_W)) u_p_clamp (
        .val_i (p_raw),
        .lim_i (p_lim),
        .val_o (p_sat)
    );

    shpid_sym_clamp #(.IN_W(WIDE_W), .LIM_W(LIM_W)) u_acc_clamp (
        .val_i (acc_raw),
        .lim_i (i_lim),
        .val_o (acc_sat)
    );

    shpid_sym_clamp #(.IN_W(WIDE_W), .LIM_W(LIM_W)) u_d_clamp (
        .val_i (d_raw),
        .lim_i (d_lim),
        .val_o (d_sat)
    );

    shpid_range_clamp #(.IN_W(WIDE_W), .OUT_W(DUTY_W)) u_duty_clamp (
        .val_i (sum_raw),
        .lo_i  (duty_min),
        .hi_i  (duty_max),
        .val_o (duty_sat)
    );

    // second integral stage: arithmetic right shift floors negative values
    assign i_new = acc_sat >>> ki_post_shift;

    always_comb begin
        st_d = st_q;
        case (phase_q)
            PH_IDLE:  if (start) st_d.err = err_new;
            PH_PROP:  st_d.pterm = p_sat;
            PH_INTEG: begin
                st_d.acc   = acc_sat;
                st_d.iterm = i_new;
            end
            PH_DERIV: begin
                st_d.dterm = d_sat;
                st_d.eprev = st_q.err;
            end
            PH_SUM: begin
                st_d.duty  = duty_sat;
                st_d.valid = 1'b1;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty = st_q.valid ? st_q.duty : duty_min;

    AST_P_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INTEG) |-> (st_q.pterm <= $signed({1'b0, $past(p_lim)}) &&
                                   st_q.pterm >= -$signed({1'b0, $past(p_lim)})))
        else $error("proportional term out of bound"); // R2
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DERIV) |-> (st_q.acc <= $signed({1'b0, $past(i_lim)}) &&
                                   st_q.acc >= -$signed({1'b0, $past(i_lim)})))
        else $error("accumulator out of bound"); // R3
    AST_D_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SUM) |-> (st_q.dterm <= $signed({1'b0, $past(d_lim)}) &&
                                 st_q.dterm >= -$signed({1'b0, $past(d_lim)})))
        else $error("derivative term out of bound"); // R5
    AST_EPREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SUM) |-> (st_q.eprev == st_q.err))
        else $error("previous error not updated"); // R5
    AST_DUTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(duty_min <= duty_max)) |->
            (duty >= $past(duty_min) && duty <= $past(duty_max)))
        else $error("duty outside window"); // R6
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_q) != PH_SUM) |-> $stable(st_q.duty))
        else $error("duty changed without done"); // R9
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> (duty == duty_min))
        else $error("duty not at minimum before first result"); // R8

endmodule

// File: tb/shift_pid_ctrl_tb.sv
module shift_pid_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [9:0]  sample;
    logic [9:0]  setpoint;
    logic [2:0]  kp_shift, ki_pre_shift, ki_post_shift, kd_shift;
    logic [14:0] p_lim, i_lim, d_lim;
    logic [7:0]  duty_min, duty_max;
    logic [7:0]  duty;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    int m_acc, m_eprev, m_duty;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_pid_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sample(sample), .setpoint(setpoint),
        .kp_shift(kp_shift), .ki_pre_shift(ki_pre_shift), .ki_post_shift(ki_post_shift),
        .kd_shift(kd_shift), .p_lim(p_lim), .i_lim(i_lim), .d_lim(d_lim),
        .duty_min(duty_min), .duty_max(duty_max), .duty(duty), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sclamp(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    task automatic set_cfg(input int kp, input int kpre, input int kpost, input int kd,
                           input int pl, input int il, input int dl, input int dmn, input int dmx);
        kp_shift = kp[2:0]; ki_pre_shift = kpre[2:0]; ki_post_shift = kpost[2:0]; kd_shift = kd[2:0];
        p_lim = pl[14:0]; i_lim = il[14:0]; d_lim = dl[14:0];
        duty_min = dmn[7:0]; duty_max = dmx[7:0];
    endtask

    task automatic do_reset();
        start = 1'b0; sample = '0; setpoint = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_acc = 0; m_eprev = 0; m_duty = int'(duty_min);
    endtask

    // one period: model the expected result, apply it, check timing and value
    task automatic run_step(input int smp, input int sp, input bit busy_start, input string tag);
        int e, p, i, d, s, expd;
        e = sp - smp;
        p = sclamp(e <<< int'(kp_shift), int'(p_lim));
        m_acc = sclamp(m_acc + (e <<< int'(ki_pre_shift)), int'(i_lim));
        i = m_acc >>> int'(ki_post_shift);
        d = sclamp((e - m_eprev) <<< int'(kd_shift), int'(d_lim));
        m_eprev = e;
        s = p + i + d;
        if (s < int'(duty_min)) expd = int'(duty_min);
        else if (s > int'(duty_max)) expd = int'(duty_max);
        else expd = s;

        @(negedge clk);
        sample = smp[9:0]; setpoint = sp[9:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 done early", int'(done), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start = (busy_start && k == 0);
            chk(done == 1'b0, "R7 done early", int'(done), 0);
        end
        chk(duty == m_duty[7:0], "R9 duty held before done", int'(duty), m_duty);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R7 done at fifth edge", int'(done), 1);
        chk(duty == expd[7:0], tag, int'(duty), expd);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
        m_duty = expd;
    endtask

    task automatic t_reset();
        set_cfg(2, 0, 3, 1, 1000, 1000, 1000, 8, 160);
        do_reset();
        chk(duty == 8'd8, "R8 reset duty equals minimum", int'(duty), 8);
        chk(done == 1'b0, "R8 reset done low", int'(done), 0);
        duty_min = 8'd12;
        @(negedge clk);
        chk(duty == 8'd12, "R8 duty follows minimum before first result", int'(duty), 12);
        duty_min = 8'd8;
    endtask

    task automatic t_prop();
        set_cfg(2, 0, 0, 0, 1000, 0, 0, 8, 160);
        do_reset();
        run_step(500, 512, 1'b0, "R1 R2 positive error times four");
        run_step(530, 512, 1'b0, "R1 negative error gives minimum duty");
        p_lim = 15'd20;
        run_step(500, 512, 1'b0, "R2 proportional limit");
    endtask

    task automatic t_integ();
        set_cfg(0, 2, 3, 0, 0, 400, 0, 0, 200);
        do_reset();
        for (int k = 0; k < 12; k++) run_step(502, 512, 1'b0, "R3 accumulate and saturate");
        chk(m_acc == 400, "R3 model accumulator saturated", m_acc, 400);
        set_cfg(2, 3, 3, 0, 300, 400, 0, 0, 200);
        do_reset();
        run_step(532, 512, 1'b0, "R3 negative accumulation");
        run_step(532, 512, 1'b0, "R3 negative accumulation");
        ki_pre_shift = 3'd0;
        run_step(462, 512, 1'b0, "R4 floor of negative accumulator gives 166");
    endtask

    task automatic t_deriv();
        set_cfg(0, 0, 0, 2, 0, 0, 150, 0, 200);
        do_reset();
        run_step(502, 512, 1'b0, "R5 first derivative against cleared previous error");
        run_step(482, 512, 1'b0, "R5 rising error");
        run_step(482, 512, 1'b0, "R5 flat error gives zero");
        run_step(507, 512, 1'b0, "R5 falling error");
        run_step(452, 512, 1'b0, "R5 derivative limit");
    endtask

    task automatic t_duty_clamp();
        set_cfg(3, 0, 0, 0, 5000, 0, 0, 10, 120);
        do_reset();
        run_step(412, 512, 1'b0, "R6 sum above maximum");
        run_step(511, 512, 1'b0, "R6 sum below minimum");
        duty_min = 8'd100; duty_max = 8'd50;
        run_step(511, 512, 1'b0, "R6 crossed limits minimum wins");
        run_step(412, 512, 1'b0, "R6 crossed limits upper side");
    endtask

    task automatic t_busy_and_hold();
        set_cfg(1, 1, 2, 1, 500, 500, 500, 0, 200);
        do_reset();
        run_step(480, 512, 1'b1, "R7 start during computation ignored");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 no second done from busy start", int'(done), 0);
        end
        run_step(490, 512, 1'b0, "R7 model advanced once only");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sample = 10'(k * 97); setpoint = 10'(1000 - k * 31); duty_min = 8'(k * 9);
            chk(duty == m_duty[7:0], "R9 duty held while inputs move", int'(duty), m_duty);
        end
        duty_min = 8'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        sample = '0;
        setpoint = '0;
        t_reset();
        t_prop();
        t_integ();
        t_deriv();
        t_duty_clamp();
        t_busy_and_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule